// File: doc/BRIEF.md
# Fail-Safe PWM Dimming Channel

This block is the dimming path of one LED current-output channel when the driver runs standalone, with no host, in fail-safe operation. A per-channel source select picks one of two external fail-safe levels. A per-channel enable then gates that level. The result switches the channel's PWM waveform on or off at the output. The block also returns a live copy of both fail-safe levels as flags.

The 12-bit duty value comes from the configuration in one of two ways:

- **Linear:** an 8-bit upper field is concatenated with a 4-bit lower field.
- **Exponential:** the 8-bit field passes through a computed exponential curve, and the lower field is ignored.

A 12-bit counter advances once per prescaled oscillator tick, so one PWM period is 4096 counter steps. A 4-bit code selects the PWM frequency. Duty and frequency are captured only when the counter wraps, so a configuration write never cuts a period short.

Top module: `fsdim_channel`

## Requirements
- R1: `src_sel`=1 routes `fs1_in` to the channel and `src_sel`=0 routes `fs0_in`; the input that is not selected has no effect on `drive_on`.
- R2: `drive_on` can be 1 only when `ch_en`=1 and the selected fail-safe level is 1. It follows a change of either one clock later.
- R3: `fs_flag[0]` equals `fs0_in` and `fs_flag[1]` equals `fs1_in`, each delayed by one clock.
- R4: With `exp_en`=0, the duty D = {`duty_hi`, `duty_lo`}, where `duty_hi` supplies bits 11:4.
- R5: With `exp_en`=1, `duty_lo` is ignored. For x = `duty_hi` below 255, D = floor(((32 + x mod 32)·2^(x div 32) − 32)/2), which gives 0 for x=0. For x=255, D = 4095. The curve never decreases.
- R6: When gated on, `drive_on` is high for the first D of the 4096 counter steps in each period. D=0 keeps it low, and D=4095 leaves exactly one low step per period.
- R7: `freq_code` 0..15 selects 200, 250, 300, 350, 400, 500, 600, 800, 1000, 1200, 2000, 4000, 5900, 7800, 9600 and 20800 Hz. One counter step lasts P ticks, where P = round(TICK_HZ / (f·4096)) with a minimum of 1. At the default TICK_HZ, codes 15, 14 and 13 give P = 1, 2 and 3.
- R8: A change of duty or `freq_code` takes effect only at the next counter wrap. A pulse that has already started completes with its old width.
- R9: During reset, `drive_on` and `fs_flag` are 0. The first tick after reset loads the configuration, so the first period already uses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator base tick enable |
| fs0_in | input | 1 | Fail-safe input level 0 |
| fs1_in | input | 1 | Fail-safe input level 1 |
| src_sel | input | 1 | Fail-safe source select (1 = input 1) |
| ch_en | input | 1 | Channel enable |
| exp_en | input | 1 | Exponential duty curve enable |
| duty_hi | input | 8 | Upper duty field |
| duty_lo | input | 4 | Lower duty field (linear mode only) |
| freq_code | input | 4 | PWM frequency code |
| drive_on | output | 1 | Channel current on/off drive |
| fs_flag | output | 2 | Live fail-safe input levels |

## Verification
A corrupted step counter or prescale count shows up at `drive_on` as a pulse whose width is not D·P cycles. The bench measures every pulse it checks, so this appears within one PWM period. A stale or early-loaded duty register produces a pulse with the wrong width, either the one in progress or the first one after a configuration change, and is visible within two periods. A wrong select or gating state appears at `drive_on` one clock after the fail-safe levels or the enable change. A wrong flag register appears at `fs_flag` on the next clock.

// File: rtl/fsdim_pkg.sv
package fsdim_pkg;

    localparam int DUTY_W = 12;
    localparam int HI_W   = 8;
    localparam int LO_W   = 4;
    localparam int CODE_W = 4;
    localparam int NCODES = 1 << CODE_W;
    localparam int STEPS  = 1 << DUTY_W;

    // PWM frequency in Hz for each code; non-uniform spacing
    function automatic int unsigned code_hz(input logic [CODE_W-1:0] c);
        case (c)
            4'h0: return 200;    4'h1: return 250;
            4'h2: return 300;    4'h3: return 350;
            4'h4: return 400;    4'h5: return 500;
            4'h6: return 600;    4'h7: return 800;
            4'h8: return 1000;   4'h9: return 1200;
            4'hA: return 2000;   4'hB: return 4000;
            4'hC: return 5900;   4'hD: return 7800;
            4'hE: return 9600;   default: return 20800;
        endcase
    endfunction

    // ticks per counter step, rounded, never below one
    function automatic int unsigned prescale_for(input int unsigned tick_hz,
                                                 input logic [CODE_W-1:0] c);
        int unsigned den;
        int unsigned q;
        den = code_hz(c) * STEPS;
        q   = (tick_hz + den / 2) / den;
        return (q < 1) ? 1 : q;
    endfunction

    // exponential curve: mantissa 32..63 shifted by the segment number
    function automatic logic [DUTY_W-1:0] exp_curve(input logic [HI_W-1:0] x);
        int unsigned v;
        if (x == '1) return '1;
        v = ((32'd32 + 32'(x[4:0])) << x[7:5]) - 32'd32;
        return DUTY_W'(v >> 1);
    endfunction

endpackage

// File: rtl/fsdim_gate.sv
module fsdim_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fs0_in,
    input  logic       fs1_in,
    input  logic       src_sel,
    input  logic       ch_en,
    output logic       level,
    output logic [1:0] fs_flag
);
    typedef struct packed {
        logic [1:0] flag;
    } gate_st_t;

    gate_st_t st_d, st_q;

    assign level = ch_en & (src_sel ? fs1_in : fs0_in);

    always_comb begin
        st_d      = st_q;
        st_d.flag = {fs1_in, fs0_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fs_flag = st_q.flag;

    p_flags_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (fs_flag == $past({fs1_in, fs0_in})))
        else $error("R3 flag mismatch");
endmodule

// File: rtl/fsdim_duty.sv
module fsdim_duty
    import fsdim_pkg::*;
(
    input  logic              exp_en,
    input  logic [HI_W-1:0]   duty_hi,
    input  logic [LO_W-1:0]   duty_lo,
    output logic [DUTY_W-1:0] duty
);
    logic [DUTY_W-1:0] lin_d;
    logic [DUTY_W-1:0] exp_d;

    assign lin_d = {duty_hi, duty_lo};
    assign exp_d = exp_curve(duty_hi);

    always_comb begin
        duty = exp_en ? exp_d : lin_d;
        if (exp_en && duty_hi == '1)
            p_exp_top_r5: assert (duty == '1) else $error("R5 curve top");
    end
endmodule

// File: rtl/fsdim_pwm.sv
module fsdim_pwm
    import fsdim_pkg::*;
#(
    parameter int unsigned TICK_HZ = 85_196_800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [CODE_W-1:0] code_in,
    output logic              pwm_on
);
    localparam int unsigned PRE_MAX = prescale_for(TICK_HZ, '0);
    localparam int          PRE_W   = $clog2(PRE_MAX + 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre_cnt;
        logic [PRE_W-1:0]  pre_act;
        logic [DUTY_W-1:0] cnt;
        logic [DUTY_W-1:0] duty_act;
        logic              on;
    } pwm_st_t;

    pwm_st_t st_d, st_q;
    logic [PRE_W-1:0] pre_tab [NCODES];
    logic step;

    for (genvar g = 0; g < NCODES; g++) begin : g_pre
        assign pre_tab[g] = PRE_W'(prescale_for(TICK_HZ, CODE_W'(g)));
    end

    assign step = tick && (st_q.pre_cnt == st_q.pre_act - 1'b1);

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.pre_cnt = '0;
            st_d.cnt     = st_q.cnt + 1'b1;
            if (st_q.cnt == '1) begin
                st_d.duty_act = duty_in;
                st_d.pre_act  = pre_tab[code_in];
            end
        end else if (tick) begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end
        st_d.on = (st_d.cnt < st_d.duty_act);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pre_cnt  <= '0;
            st_q.pre_act  <= PRE_W'(1);
            st_q.cnt      <= '1;
            st_q.duty_act <= '0;
            st_q.on       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_on = st_q.on;

    p_hold_until_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> ($stable(st_q.duty_act) && $stable(st_q.pre_act)))
        else $error("R8 config changed mid-period");

    p_pre_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre_cnt < st_q.pre_act) && (st_q.pre_act != '0))
        else $error("R7 prescale out of range");

    p_zero_duty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.duty_act == '0) |-> !st_q.on)
        else $error("R6 output high at zero duty");
endmodule

// File: rtl/fsdim_channel.sv
module fsdim_channel
    import fsdim_pkg::*;
#(
    parameter int unsigned TICK_HZ = 85_196_800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              fs0_in,
    input  logic              fs1_in,
    input  logic              src_sel,
    input  logic              ch_en,
    input  logic              exp_en,
    input  logic [HI_W-1:0]   duty_hi,
    input  logic [LO_W-1:0]   duty_lo,
    input  logic [CODE_W-1:0] freq_code,
    output logic              drive_on,
    output logic [1:0]        fs_flag
);
    typedef struct packed {
        logic drive;
    } top_st_t;

    top_st_t st_d, st_q;
    logic level;
    logic pwm_on;
    logic [DUTY_W-1:0] duty;

    fsdim_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs0_in  (fs0_in),
        .fs1_in  (fs1_in),
        .src_sel (src_sel),
        .ch_en   (ch_en),
        .level   (level),
        .fs_flag (fs_flag)
    );

    fsdim_duty u_duty (
        .exp_en  (exp_en),
        .duty_hi (duty_hi),
        .duty_lo (duty_lo),
        .duty    (duty)
    );

    fsdim_pwm #(.TICK_HZ(TICK_HZ)) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (osc_tick),
        .duty_in (duty),
        .code_in (freq_code),
        .pwm_on  (pwm_on)
    );

    always_comb begin
        st_d       = st_q;
        st_d.drive = pwm_on & level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_on = st_q.drive;

    p_drive_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |-> $past(ch_en))
        else $error("R2 drive without enable");

    p_sel_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |-> $past(src_sel ? fs1_in : fs0_in))
        else $error("R1 drive from unselected source");
endmodule

// File: tb/tb_fsdim_channel.sv
module tb_fsdim_channel;
    localparam int unsigned TICK = 85_196_800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b1;
    logic fs0_in = 1'b1, fs1_in = 1'b0, src_sel = 1'b0, ch_en = 1'b1, exp_en = 1'b0;
    logic [7:0] duty_hi = 8'h06;
    logic [3:0] duty_lo = 4'h4, freq_code = 4'hF;
    logic drive_on;
    logic [1:0] fs_flag;

    int checks = 0;
    int errors = 0;
    bit mon_busy = 0;
    bit done = 0;

    typedef struct {
        int    width;
        int    period;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    fsdim_channel #(.TICK_HZ(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .fs0_in(fs0_in), .fs1_in(fs1_in), .src_sel(src_sel), .ch_en(ch_en),
        .exp_en(exp_en), .duty_hi(duty_hi), .duty_lo(duty_lo),
        .freq_code(freq_code), .drive_on(drive_on), .fs_flag(fs_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_model(input int x);
        if (x == 255) return 4095;
        return ((32 + x % 32) * (2 ** (x / 32)) - 32) / 2;
    endfunction

    function automatic int pre_model(input int code);
        int hz [16] = '{200, 250, 300, 350, 400, 500, 600, 800,
                        1000, 1200, 2000, 4000, 5900, 7800, 9600, 20800};
        int den;
        int q;
        den = hz[code] * 4096;
        q = (int'(TICK) + den / 2) / den;
        return (q < 1) ? 1 : q;
    endfunction

    // monitor: measures pulses and compares with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                int w;
                it = exp_q.pop_front();
                mon_busy = 1;
                if (it.width == 0) begin
                    w = 0;
                    repeat (it.period + 8) begin
                        @(negedge clk);
                        if (drive_on) w++;
                    end
                    check(w == 0, it.tag, w, 0);
                end else begin
                    while (drive_on) @(negedge clk);
                    while (!drive_on) @(negedge clk);
                    w = 0;
                    while (drive_on) begin
                        w++;
                        @(negedge clk);
                    end
                    check(w == it.width, it.tag, w, it.width);
                end
                mon_busy = 0;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic expect_pulse(input int width, input int pre, input string tag);
        item_t it;
        it.width = width;
        it.period = 4096 * pre;
        it.tag = tag;
        exp_q.push_back(it);
        wait_idle();
    endtask

    task automatic settle(input int pre);
        repeat (4096 * pre + 4) @(negedge clk);
    endtask

    task automatic set_duty(input bit e, input int hi, input int lo);
        exp_en = e;
        duty_hi = 8'(hi);
        duty_lo = 4'(lo);
    endtask

    task automatic any_high(input int n, output bit seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (drive_on) seen = 1;
        end
    endtask

    initial begin
        bit seen;
        repeat (5) @(negedge clk);
        check(drive_on == 1'b0, "R9 reset drive", int'(drive_on), 0);
        check(fs_flag == 2'b00, "R9 reset flags", int'(fs_flag), 0);
        rst_n = 1'b1;
        expect_pulse(100, 1, "R9 first period uses config");

        set_duty(0, 8'h12, 4'h3); settle(1);
        expect_pulse(291, 1, "R4 linear concat");
        set_duty(0, 8'hFF, 4'hF); settle(1);
        expect_pulse(4095, 1, "R6 full scale");
        set_duty(0, 0, 0); settle(1);
        expect_pulse(0, 1, "R6 zero duty");

        set_duty(1, 128, 4'hF); settle(1);
        expect_pulse(exp_model(128), 1, "R5 exp mid, low field ignored");
        set_duty(1, 200, 0); settle(1);
        expect_pulse(exp_model(200), 1, "R5 exp 200");
        set_duty(1, 255, 0); settle(1);
        expect_pulse(4095, 1, "R5 exp top");
        set_duty(1, 0, 4'hF); settle(1);
        expect_pulse(0, 1, "R5 exp zero");

        // R8: change duty while a pulse is in progress
        set_duty(0, 8'h80, 0); settle(1);
        while (drive_on) @(negedge clk);
        begin
            item_t it;
            it.width = 2048; it.period = 4096; it.tag = "R8 pulse in progress keeps width";
            exp_q.push_back(it);
        end
        while (!drive_on) @(negedge clk);
        repeat (100) @(negedge clk);
        set_duty(0, 8'h06, 4'h4);
        wait_idle();
        expect_pulse(100, 1, "R8 new duty at next wrap");

        // R7: one-step pulse width equals the prescale
        set_duty(0, 0, 1);
        freq_code = 4'hE; settle(1);
        expect_pulse(pre_model(14), pre_model(14), "R7 code E prescale");
        freq_code = 4'hD; settle(pre_model(14));
        expect_pulse(pre_model(13), pre_model(13), "R7 code D prescale");

        // gating and routing with near full duty
        set_duty(0, 8'hFF, 4'hF); freq_code = 4'hF; settle(pre_model(13));
        src_sel = 0; fs0_in = 1; fs1_in = 0; ch_en = 1;
        any_high(4, seen); check(seen, "R1 select FS0 high", int'(seen), 1);
        src_sel = 1; @(negedge clk);
        any_high(8, seen); check(!seen, "R1 select FS1 low", int'(seen), 0);
        fs1_in = 1; fs0_in = 0;
        any_high(4, seen); check(seen, "R1 FS1 drives, FS0 ignored", int'(seen), 1);
        ch_en = 0; @(negedge clk);
        any_high(8, seen); check(!seen, "R2 disabled channel", int'(seen), 0);
        ch_en = 1; fs1_in = 0; fs0_in = 1; @(negedge clk);
        any_high(8, seen); check(!seen, "R2 selected level low", int'(seen), 0);

        fs0_in = 1; fs1_in = 0;
        @(negedge clk); @(negedge clk);
        check(fs_flag == 2'b01, "R3 flags 01", int'(fs_flag), 1);
        fs0_in = 0; fs1_in = 1;
        @(negedge clk);
        check(fs_flag == 2'b10, "R3 flags 10", int'(fs_flag), 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule